// File: doc/BRIEF.md
# Branch Hazard Stall/Squash Controller

This block is the control-hazard logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Conditional branches and register jumps get their target and their outcome in execute, and they redirect the program counter only once they reach the memory stage. The controller owns the fetch program counter. It keeps a shadow valid/branch/PC record for each stage, and it drives the stage-kill controls that the datapath applies to its pipeline registers.

A parameter fixes one of two policies. In the freeze policy, a branch seen in decode stops fetch and feeds bubbles into decode until the branch reaches memory. Fetch then resumes at the target or at the fall-through address. In the speculative policy, fetch keeps running down the fall-through path. When a branch resolves taken, the three younger instructions in decode, execute and memory are replaced by bubbles and the target is loaded into the PC.

The datapath reads the instruction at `id_pc` and returns its opcode on `id_opcode`. It presents the outcome of the branch at `mem_pc` on `mem_taken` and `mem_target`, and it retires whatever `wb_valid`/`wb_pc` report.

Top module: `hz_branch_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, `pc` is 0 and `wb_valid` is 0. The first instruction (PC 0) commits on the fourth rising edge after reset is released.
- R2: Freeze policy: while a valid decode slot holds opcode 3'b100 (conditional branch) or 3'b101 (register jump), or such a branch sits in execute, `ifid_hold` and `noop_id` are 1 and `pc_we` is 0. `noop_ex` and `noop_mem` are never asserted. A branch therefore holds fetch for exactly two cycles.
- R3: Freeze policy: when the branch reaches memory, the PC loads `mem_target` if `mem_taken` is 1 and PC+1 otherwise. The commit of the next instruction follows the branch by 4 cycles if the branch is taken and by 3 cycles if it is not.
- R4: Speculative policy: `pc_we` is 1 in every cycle and `ifid_hold` is never asserted. A not-taken branch adds no cycle, so the two policies finish the same program 2 cycles apart per not-taken branch.
- R5: Speculative policy: a taken branch in memory asserts `noop_id`, `noop_ex` and `noop_mem` together and loads `mem_target` into the PC. The target commits 4 cycles after the branch.
- R6: The sequence of `wb_pc` values seen with `wb_valid` equals the program executed in order. No squashed or stalled-out instruction ever commits.
- R7: A branch on the wrong path behind a taken branch never resolves: `mem_resolve` pulses exactly once per branch on the executed path, and the memory stage is empty in the cycle after a taken resolution.
- R8: `pc_sel` is 1 only in a cycle where a taken branch resolves in memory, and then `pc_we` is also 1.
- R9: Opcodes other than 3'b100 and 3'b101 never stall or redirect, and the opcode input is ignored while the decode slot holds a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_opcode | input | OPW | Opcode of the instruction at `id_pc` |
| mem_taken | input | 1 | Outcome of the branch at `mem_pc` (1 = taken) |
| mem_target | input | AW | Target of the branch at `mem_pc` |
| pc | output | AW | Fetch program counter |
| pc_we | output | 1 | PC update enable this cycle |
| pc_sel | output | 1 | 1 = next PC is `mem_target`, 0 = PC+1 |
| ifid_hold | output | 1 | Fetch frozen this cycle |
| noop_id | output | 1 | Bubble into decode at next edge |
| noop_ex | output | 1 | Bubble into execute at next edge |
| noop_mem | output | 1 | Bubble into memory at next edge |
| id_pc | output | AW | PC of the decode slot |
| mem_pc | output | AW | PC of the memory slot |
| mem_resolve | output | 1 | A valid branch is in memory this cycle |
| wb_valid | output | 1 | An instruction commits this cycle |
| wb_pc | output | AW | PC of the committing instruction |

## Verification
In the speculative policy, a taken resolution in memory can coincide with the detection of a younger branch in decode or execute. The squash must win, and that younger branch must never reach memory. The program places branches, including a register jump, directly behind taken branches to provoke this. The result is judged by the commit stream and by counting `mem_resolve` pulses against the branches that were really executed. The freeze policy has its own overlap: a taken redirect leaves a branch opcode at `id_pc` inside a bubble. The fixed commit spacing shows whether that bubble was wrongly decoded.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Branch hazard policy chosen at elaboration.
  typedef enum logic [0:0] {
    HZ_STALL     = 1'b0,
    HZ_SPECULATE = 1'b1
  } hz_mode_e;

  // Number of tracked stages after fetch: decode, execute, memory, writeback.
  localparam int HZ_NSTAGE = 4;

endpackage

// File: rtl/hz_decode_detect.sv
module hz_decode_detect #(
  parameter int               OPW    = 3,
  parameter logic [OPW-1:0]   BEQ_OP = 3'b100,
  parameter logic [OPW-1:0]   JMP_OP = 3'b101
) (
  input  logic           id_valid,
  input  logic [OPW-1:0] id_opcode,
  output logic           id_is_branch
);

  function automatic logic op_redirects(input logic [OPW-1:0] op);
    return (op == BEQ_OP) || (op == JMP_OP);
  endfunction

  // A bubble in decode carries a stale PC, so its opcode must be ignored.
  assign id_is_branch = id_valid && op_redirects(id_opcode);

endmodule

// File: rtl/hz_fetch_pc.sv
module hz_fetch_pc #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_we,
  input  logic          pc_sel,
  input  logic [AW-1:0] redirect_pc,
  output logic [AW-1:0] pc
);

  function automatic logic [AW-1:0] next_pc(input logic [AW-1:0] cur,
                                            input logic          sel,
                                            input logic [AW-1:0] tgt);
    return sel ? tgt : cur + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     pc <= '0;
    else if (pc_we) pc <= next_pc(pc, pc_sel, redirect_pc);
  end

endmodule

// File: rtl/hz_stage_track.sv
module hz_stage_track
  import hz_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc,
  input  logic          id_is_branch,
  input  logic          noop_id,
  input  logic          noop_ex,
  input  logic          noop_mem,
  output logic          id_valid,
  output logic [AW-1:0] id_pc,
  output logic          ex_valid,
  output logic          ex_branch,
  output logic          mem_valid,
  output logic          mem_branch,
  output logic [AW-1:0] mem_pc,
  output logic          wb_valid,
  output logic [AW-1:0] wb_pc
);

  localparam int NST = HZ_NSTAGE;

  // Index 0 = decode, 1 = execute, 2 = memory, 3 = writeback.
  logic          v_q  [NST];
  logic [AW-1:0] p_q  [NST];
  logic          br_q [1:NST-1];
  logic [NST-1:0] kill;

  assign kill = {1'b0, noop_mem, noop_ex, noop_id};

  // Decode slot: filled from fetch unless a bubble is injected.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0;
      p_q[0] <= '0;
    end else begin
      v_q[0] <= !kill[0];
      p_q[0] <= pc;
    end
  end

  for (genvar s = 1; s < NST; s++) begin : g_stage
    logic br_in;
    if (s == 1) begin : g_from_decode
      assign br_in = id_is_branch;
    end else begin : g_from_prev
      assign br_in = br_q[s-1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[s]  <= 1'b0;
        br_q[s] <= 1'b0;
        p_q[s]  <= '0;
      end else begin
        v_q[s]  <= v_q[s-1] && !kill[s];
        br_q[s] <= br_in && !kill[s];
        p_q[s]  <= p_q[s-1];
      end
    end
  end

  assign id_valid   = v_q[0];
  assign id_pc      = p_q[0];
  assign ex_valid   = v_q[1];
  assign ex_branch  = br_q[1];
  assign mem_valid  = v_q[2];
  assign mem_branch = br_q[2];
  assign mem_pc     = p_q[2];
  assign wb_valid   = v_q[3];
  assign wb_pc      = p_q[3];

endmodule

// File: rtl/hz_policy.sv
module hz_policy
  import hz_pkg::*;
#(
  parameter hz_mode_e MODE = HZ_STALL
) (
  input  logic id_is_branch,
  input  logic ex_valid,
  input  logic ex_branch,
  input  logic mem_valid,
  input  logic mem_branch,
  input  logic mem_taken,
  output logic in_flight,
  output logic resolve,
  output logic take,
  output logic stall,
  output logic pc_we,
  output logic pc_sel,
  output logic ifid_hold,
  output logic noop_id,
  output logic noop_ex,
  output logic noop_mem
);

  // An unresolved branch lives in decode or execute.
  assign in_flight = id_is_branch || (ex_valid && ex_branch);
  assign resolve   = mem_valid && mem_branch;
  assign take      = resolve && mem_taken;

  if (MODE == HZ_STALL) begin : g_freeze
    // Fetch waits; only decode receives bubbles, younger stages stay clean.
    assign stall    = in_flight;
    assign noop_ex  = 1'b0;
    assign noop_mem = 1'b0;
  end else begin : g_spec
    // Fetch runs on; a taken outcome kills the three younger slots.
    assign stall    = 1'b0;
    assign noop_ex  = take;
    assign noop_mem = take;
  end

  assign pc_we     = !stall;
  assign pc_sel    = take;
  assign ifid_hold = stall;
  assign noop_id   = stall || take;

endmodule

// File: rtl/hz_branch_ctrl.sv
module hz_branch_ctrl
  import hz_pkg::*;
#(
  parameter int             AW     = 16,
  parameter int             OPW    = 3,
  parameter logic [OPW-1:0] BEQ_OP = 3'b100,
  parameter logic [OPW-1:0] JMP_OP = 3'b101,
  parameter hz_mode_e       MODE   = HZ_STALL
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] id_opcode,
  input  logic           mem_taken,
  input  logic [AW-1:0]  mem_target,
  output logic [AW-1:0]  pc,
  output logic           pc_we,
  output logic           pc_sel,
  output logic           ifid_hold,
  output logic           noop_id,
  output logic           noop_ex,
  output logic           noop_mem,
  output logic [AW-1:0]  id_pc,
  output logic [AW-1:0]  mem_pc,
  output logic           mem_resolve,
  output logic           wb_valid,
  output logic [AW-1:0]  wb_pc
);

  // Named internal events, observed by the bound checker.
  logic id_valid_w;
  logic id_branch_w;
  logic ex_valid_w;
  logic ex_branch_w;
  logic mem_valid_w;
  logic mem_branch_w;
  logic in_flight_w;
  logic resolve_w;
  logic take_w;
  logic stall_w;

  hz_decode_detect #(
    .OPW    (OPW),
    .BEQ_OP (BEQ_OP),
    .JMP_OP (JMP_OP)
  ) u_detect (
    .id_valid     (id_valid_w),
    .id_opcode    (id_opcode),
    .id_is_branch (id_branch_w)
  );

  hz_policy #(
    .MODE (MODE)
  ) u_policy (
    .id_is_branch (id_branch_w),
    .ex_valid     (ex_valid_w),
    .ex_branch    (ex_branch_w),
    .mem_valid    (mem_valid_w),
    .mem_branch   (mem_branch_w),
    .mem_taken    (mem_taken),
    .in_flight    (in_flight_w),
    .resolve      (resolve_w),
    .take         (take_w),
    .stall        (stall_w),
    .pc_we        (pc_we),
    .pc_sel       (pc_sel),
    .ifid_hold    (ifid_hold),
    .noop_id      (noop_id),
    .noop_ex      (noop_ex),
    .noop_mem     (noop_mem)
  );

  hz_fetch_pc #(
    .AW (AW)
  ) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_we       (pc_we),
    .pc_sel      (pc_sel),
    .redirect_pc (mem_target),
    .pc          (pc)
  );

  hz_stage_track #(
    .AW (AW)
  ) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc           (pc),
    .id_is_branch (id_branch_w),
    .noop_id      (noop_id),
    .noop_ex      (noop_ex),
    .noop_mem     (noop_mem),
    .id_valid     (id_valid_w),
    .id_pc        (id_pc),
    .ex_valid     (ex_valid_w),
    .ex_branch    (ex_branch_w),
    .mem_valid    (mem_valid_w),
    .mem_branch   (mem_branch_w),
    .mem_pc       (mem_pc),
    .wb_valid     (wb_valid),
    .wb_pc        (wb_pc)
  );

  assign mem_resolve = resolve_w;

endmodule

// File: rtl/hz_branch_ctrl_chk.sv
module hz_branch_ctrl_chk
  import hz_pkg::*;
#(
  parameter int       AW   = 16,
  parameter hz_mode_e MODE = HZ_STALL
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] mem_target,
  input logic          pc_we,
  input logic          pc_sel,
  input logic          ifid_hold,
  input logic          noop_id,
  input logic          noop_ex,
  input logic          noop_mem,
  input logic          in_flight,
  input logic          resolve,
  input logic          take
);

  assert_sel_needs_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |-> (pc_we && resolve && take));

  assert_seq_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && !pc_sel) |=> (pc == AW'($past(pc) + AW'(1))));

  assert_redirect_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel |=> (pc == $past(mem_target)));

  assert_frozen_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc));

  assert_no_wrong_path_resolve_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !resolve);

  if (MODE == HZ_STALL) begin : g_freeze_chk
    assert_hold_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight |-> (ifid_hold && noop_id && !pc_we));

    assert_no_deep_kill_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(noop_ex || noop_mem));
  end else begin : g_spec_chk
    assert_fetch_runs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_flight |-> (pc_we && !ifid_hold));

    assert_triple_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (noop_id && noop_ex && noop_mem));
  end

endmodule

bind hz_branch_ctrl hz_branch_ctrl_chk #(
  .AW   (AW),
  .MODE (MODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pc         (pc),
  .mem_target (mem_target),
  .pc_we      (pc_we),
  .pc_sel     (pc_sel),
  .ifid_hold  (ifid_hold),
  .noop_id    (noop_id),
  .noop_ex    (noop_ex),
  .noop_mem   (noop_mem),
  .in_flight  (in_flight_w),
  .resolve    (resolve_w),
  .take       (take_w)
);

// File: tb/hz_branch_ctrl_test.sv
module hz_branch_ctrl_test;
  import hz_pkg::*;

  localparam int          AW     = 6;
  localparam int          OPW    = 3;
  localparam logic [2:0]  OP_BEQ = 3'b100;
  localparam logic [2:0]  OP_JMP = 3'b101;
  localparam logic [2:0]  OP_ALU = 3'b000;
  localparam int          END_PC = 48;
  localparam int          WD_LIM = 2000;

  typedef struct {
    logic [AW-1:0] pc;
    int            gap;
    int            kind;   // 0 first, 1 plain, 2 not-taken branch, 3 taken branch
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Program image: opcode, outcome and target per address.
  logic [2:0]    p_op [64];
  logic          p_tk [64];
  logic [AW-1:0] p_tg [64];

  // Lane a: freeze policy (uut). Lane b: speculative policy.
  logic [OPW-1:0] op_a, op_b;
  logic           tk_a, tk_b;
  logic [AW-1:0]  tg_a, tg_b;
  logic [AW-1:0]  pc_a, pc_b, idpc_a, idpc_b, mpc_a, mpc_b, wpc_a, wpc_b;
  logic           we_a, we_b, sel_a, sel_b, hold_a, hold_b;
  logic           nid_a, nid_b, nex_a, nex_b, nmem_a, nmem_b;
  logic           res_a, res_b, wv_a, wv_b;

  assign op_a = p_op[idpc_a];
  assign op_b = p_op[idpc_b];
  assign tk_a = p_tk[mpc_a];
  assign tk_b = p_tk[mpc_b];
  assign tg_a = p_tg[mpc_a];
  assign tg_b = p_tg[mpc_b];

  hz_branch_ctrl #(.AW(AW), .OPW(OPW), .BEQ_OP(OP_BEQ), .JMP_OP(OP_JMP), .MODE(HZ_STALL)) uut (
    .clk(clk), .rst_n(rst_n), .id_opcode(op_a), .mem_taken(tk_a), .mem_target(tg_a),
    .pc(pc_a), .pc_we(we_a), .pc_sel(sel_a), .ifid_hold(hold_a), .noop_id(nid_a),
    .noop_ex(nex_a), .noop_mem(nmem_a), .id_pc(idpc_a), .mem_pc(mpc_a),
    .mem_resolve(res_a), .wb_valid(wv_a), .wb_pc(wpc_a));

  hz_branch_ctrl #(.AW(AW), .OPW(OPW), .BEQ_OP(OP_BEQ), .JMP_OP(OP_JMP), .MODE(HZ_SPECULATE)) uut_spec (
    .clk(clk), .rst_n(rst_n), .id_opcode(op_b), .mem_taken(tk_b), .mem_target(tg_b),
    .pc(pc_b), .pc_we(we_b), .pc_sel(sel_b), .ifid_hold(hold_b), .noop_id(nid_b),
    .noop_ex(nex_b), .noop_mem(nmem_b), .id_pc(idpc_b), .mem_pc(mpc_b),
    .mem_resolve(res_b), .wb_valid(wv_b), .wb_pc(wpc_b));

  exp_t q_a[$];
  exp_t q_b[$];
  logic done_a = 1'b0, done_b = 1'b0;
  int   last_a = 0, last_b = 0;
  int   n_hold_a = 0, n_hold_b = 0, n_sel_a = 0, n_sel_b = 0;
  int   n_nex_a = 0, n_nmem_b = 0, n_res_b = 0, n_selnowe = 0;
  int   n_taken = 0, n_nottaken = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_br(input int a, input logic [2:0] op, input logic tk, input int tg);
    p_op[a] = op;
    p_tk[a] = tk;
    p_tg[a] = AW'(tg);
  endtask

  // Driver: walks the program in order and queues the expected commits.
  task automatic build_trace(input bit spec);
    int pc = 0;
    int gap = 4;
    int kind = 0;
    int n = 0;
    while (pc != END_PC && n < 100) begin
      exp_t e;
      bit   br;
      e.pc = AW'(pc); e.gap = gap; e.kind = kind;
      if (spec) q_b.push_back(e); else q_a.push_back(e);
      br = (p_op[pc] == OP_BEQ) || (p_op[pc] == OP_JMP);
      if (br && p_tk[pc]) begin
        gap = 4; kind = 3;
        if (!spec) n_taken++;
        pc = int'(p_tg[pc]);
      end else if (br) begin
        gap = spec ? 1 : 3; kind = 2;
        if (!spec) n_nottaken++;
        pc = pc + 1;
      end else begin
        gap = 1; kind = 1;
        pc = pc + 1;
      end
      n++;
    end
  endtask

  function automatic string gap_req(input bit spec, input int kind);
    if (kind == 1) return "R9";
    if (kind == 0) return "R1";
    if (kind == 2) return spec ? "R4" : "R3";
    return spec ? "R5" : "R3";
  endfunction

  // Monitor: pops the queue on each commit and compares PC and spacing.
  task automatic monitor(input bit spec, input logic v, input logic [AW-1:0] wpc);
    exp_t e;
    int   last;
    if (!v) return;
    if (spec ? done_b : done_a) return;
    if (spec ? (q_b.size() == 0) : (q_a.size() == 0)) return;
    e    = spec ? q_b.pop_front() : q_a.pop_front();
    last = spec ? last_b : last_a;
    check(wpc == e.pc, "R6", spec ? "commit pc (spec)" : "commit pc (freeze)",
          int'(wpc), int'(e.pc));
    check((cyc - last) == e.gap, gap_req(spec, e.kind),
          spec ? "commit spacing (spec)" : "commit spacing (freeze)", cyc - last, e.gap);
    if (spec) begin
      last_b = cyc;
      if (q_b.size() == 0) done_b = 1'b1;
    end else begin
      last_a = cyc;
      if (q_a.size() == 0) done_a = 1'b1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!done_a) begin
        if (hold_a) n_hold_a++;
        if (sel_a)  n_sel_a++;
        if (nex_a || nmem_a) n_nex_a++;
        if (sel_a && !we_a) n_selnowe++;
      end
      if (!done_b) begin
        if (hold_b || !we_b) n_hold_b++;
        if (sel_b)  n_sel_b++;
        if (nmem_b && nex_b && nid_b) n_nmem_b++;
        if (res_b)  n_res_b++;
        if (sel_b && !we_b) n_selnowe++;
      end
      monitor(1'b0, wv_a, wpc_a);
      monitor(1'b1, wv_b, wpc_b);
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      p_op[i] = OP_ALU; p_tk[i] = 1'b0; p_tg[i] = '0;
    end
    set_br(2,  OP_BEQ, 1'b0, 0);
    p_op[3] = 3'b110;                 // not a branch code
    set_br(4,  OP_BEQ, 1'b1, 10);
    set_br(5,  OP_BEQ, 1'b1, 40);     // wrong path
    set_br(6,  OP_JMP, 1'b1, 41);     // wrong path
    set_br(10, OP_JMP, 1'b1, 14);
    set_br(11, OP_BEQ, 1'b1, 42);     // wrong path
    set_br(14, OP_BEQ, 1'b1, 20);
    set_br(15, OP_BEQ, 1'b1, 44);     // wrong path
    set_br(20, OP_BEQ, 1'b0, 0);
    set_br(21, OP_BEQ, 1'b0, 0);
    set_br(22, OP_BEQ, 1'b1, 30);
    set_br(23, OP_BEQ, 1'b1, 44);     // wrong path
    set_br(24, OP_JMP, 1'b1, 45);     // wrong path
    p_op[30] = 3'b001;
    p_op[31] = 3'b110;
    set_br(32, OP_BEQ, 1'b1, 33);     // taken to its own fall-through
    set_br(34, OP_BEQ, 1'b0, 0);
    set_br(36, OP_JMP, 1'b1, END_PC);
    build_trace(1'b0);
    build_trace(1'b1);

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pc_a == '0 && pc_b == '0, "R1", "pc in reset", int'(pc_a | pc_b), 0);
    check(!wv_a && !wv_b, "R1", "wb_valid in reset", int'(wv_a | wv_b), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc_a == AW'(1) && pc_b == AW'(1), "R1", "pc after first edge",
          int'(pc_a), 1);
    check(!wv_a && !wv_b, "R1", "no commit after first edge", int'(wv_a | wv_b), 0);

    while (!(done_a && done_b) && cyc < WD_LIM) @(negedge clk);
    if (!(done_a && done_b)) begin
      checks++; failures++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, WD_LIM);
    end else begin
      check(n_hold_a == 2 * (n_taken + n_nottaken), "R2", "freeze hold cycles",
            n_hold_a, 2 * (n_taken + n_nottaken));
      check(n_nex_a == 0, "R2", "freeze deep kills", n_nex_a, 0);
      check(n_sel_a == n_taken, "R3", "freeze redirects", n_sel_a, n_taken);
      check(n_hold_b == 0, "R4", "spec fetch stops", n_hold_b, 0);
      check((last_a - last_b) == 2 * n_nottaken, "R4", "policy cycle difference",
            last_a - last_b, 2 * n_nottaken);
      check(n_sel_b == n_taken, "R5", "spec redirects", n_sel_b, n_taken);
      check(n_nmem_b == n_taken, "R5", "spec triple squashes", n_nmem_b, n_taken);
      check(n_res_b == n_taken + n_nottaken, "R7", "spec resolves",
            n_res_b, n_taken + n_nottaken);
      check(n_selnowe == 0, "R8", "redirect without pc write", n_selnowe, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule